// File: doc/BRIEF.md
# PHY Basic Mode Control Register

This block is the 16-bit basic mode control register of a 10/100 Ethernet PHY. A management-bus register port writes it with a one-cycle write strobe and a 16-bit data word. It returns its contents on a read-data output that is combinational from the stored state. The stored fields drive the PHY's control lines: loopback, forced speed, auto-negotiation enable, power down and forced duplex. Two self-clearing commands produce single-cycle pulses: a software reset for the other registers, and a restart for the negotiation engine.

The block also resolves which values are in force. A fiber-mode strap forces 100 Mbps and turns auto-negotiation off, and while it is active those two bits ignore writes. When auto-negotiation is enabled and the engine reports completion, the speed and duplex bits read back the negotiated result, and the effective speed and duplex outputs follow that result.

A three-state sequencer tracks the commands. ST_IDLE is the resting state. A write with bit 15 set goes to ST_SWRST (transition "soft reset"). A write with bit 9 set and bit 15 clear goes to ST_RESTART (transition "restart"). ST_SWRST always returns to ST_IDLE on the next cycle (transition "reset done"), and any write in that cycle is ignored. ST_RESTART returns to ST_IDLE (transition "restart done") unless a new write moves it to ST_SWRST or back into ST_RESTART.

Top module: `phy_bmcr`

## Requirements
- R1: After hardware reset, rd_data is 0x1000, with only bit 12 (auto-negotiation enable) set. The loopback_en, power_down, speed_100, full_duplex and both pulse outputs are 0, and an_enable is 1.
- R2: Bit 14 is loopback. A write stores it, it reads back at bit 14, and it drives loopback_en.
- R3: With bit 12 clear and no fiber strap, bit 13 (1 = 100 Mbps) drives speed_100 and bit 8 (1 = full duplex) drives full_duplex. Both read back as written, whatever the negotiation inputs are.
- R4: With bit 12 set and an_done high, rd_data bit 13 and speed_100 follow an_speed_100, and rd_data bit 8 and full_duplex follow an_full_duplex. With an_done low, the stored bits are used.
- R5: While fiber_mode is high, rd_data bit 13 reads 1, bit 12 reads 0, speed_100 is 1 and an_enable is 0. Writes to bits 13 and 12 are ignored, and the stored values reappear once the strap is released.
- R6: Bit 11 is power down and drives power_down. While it is set, register writes still take effect.
- R7: Writing 1 to bit 9 raises an_restart_pulse for exactly the cycle after the write. Bit 9 always reads 0.
- R8: Writing 1 to bit 15 restores this register's defaults at the write edge and raises soft_reset_pulse for exactly the next cycle. Bit 15 always reads 0, and a write during the pulse cycle is ignored.
- R9: Bits 10 and 7 to 0 always read 0 and ignore writes.
- R10: A single write with both bit 15 and bit 9 set performs only the software reset. No restart pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | One-cycle register write strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read-back value |
| fiber_mode | input | 1 | Fiber-mode strap |
| an_done | input | 1 | Auto-negotiation complete |
| an_speed_100 | input | 1 | Negotiated speed, 1 = 100 Mbps |
| an_full_duplex | input | 1 | Negotiated duplex, 1 = full |
| soft_reset_pulse | output | 1 | One-cycle reset for the other registers |
| an_restart_pulse | output | 1 | One-cycle negotiation restart |
| loopback_en | output | 1 | Loopback enable |
| power_down | output | 1 | Power-down request |
| an_enable | output | 1 | Effective auto-negotiation enable |
| speed_100 | output | 1 | Effective speed, 1 = 100 Mbps |
| full_duplex | output | 1 | Effective duplex, 1 = full |

## Verification
Stored fields and rd_data change at the clock edge that samples the write, and both pulses are high for the cycle that follows that edge. The effective outputs and the read-back react combinationally to fiber_mode and to the negotiation inputs within the same cycle. The bench drives inputs on the falling edge and samples on the next falling edge, which is the first point at which a write's effects are visible. A pulse's clearing is checked one falling edge later.

// File: rtl/bmcr_pkg.sv
package bmcr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SWRST   = 2'd1,
        ST_RESTART = 2'd2
    } bmcr_state_t;

    localparam int REG_W       = 16;
    localparam int B_SWRST     = 15;
    localparam int B_LOOP      = 14;
    localparam int B_SPEED     = 13;
    localparam int B_AN_EN     = 12;
    localparam int B_PDOWN     = 11;
    localparam int B_RESTART   = 9;
    localparam int B_DUPLEX    = 8;

    localparam logic DEF_LOOP   = 1'b0;
    localparam logic DEF_SPEED  = 1'b0;
    localparam logic DEF_AN_EN  = 1'b1;
    localparam logic DEF_PDOWN  = 1'b0;
    localparam logic DEF_DUPLEX = 1'b0;
endpackage

// File: rtl/bmcr_seq.sv
module bmcr_seq
    import bmcr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic cmd_reset,
    input  logic cmd_restart,
    output logic wr_accept,
    output logic soft_reset_pulse,
    output logic an_restart_pulse
);
    bmcr_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_SWRST: state_d = ST_IDLE;
            ST_IDLE, ST_RESTART: begin
                if (wr_en && cmd_reset)        state_d = ST_SWRST;
                else if (wr_en && cmd_restart) state_d = ST_RESTART;
                else                           state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        wr_accept        = wr_en && (state_q != ST_SWRST);
        soft_reset_pulse = (state_q == ST_SWRST);
        an_restart_pulse = (state_q == ST_RESTART);
    end

    assert_swrst_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_reset_pulse |=> !soft_reset_pulse);
    assert_swrst_follows_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cmd_reset && !soft_reset_pulse) |=> soft_reset_pulse);
    assert_restart_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cmd_restart && !cmd_reset && !soft_reset_pulse) |=> an_restart_pulse);
    assert_reset_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cmd_reset) |=> !an_restart_pulse);
endmodule

// File: rtl/bmcr_fields.sv
module bmcr_fields
    import bmcr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_accept,
    input  logic cmd_reset,
    input  logic fiber_mode,
    input  logic d_loop,
    input  logic d_speed,
    input  logic d_an_en,
    input  logic d_pdown,
    input  logic d_duplex,
    output logic q_loop,
    output logic q_speed,
    output logic q_an_en,
    output logic q_pdown,
    output logic q_duplex
);
    logic load_def, load_new;

    always_comb begin
        load_def = wr_accept && cmd_reset;
        load_new = wr_accept && !cmd_reset;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_loop   <= DEF_LOOP;
            q_speed  <= DEF_SPEED;
            q_an_en  <= DEF_AN_EN;
            q_pdown  <= DEF_PDOWN;
            q_duplex <= DEF_DUPLEX;
        end else if (load_def) begin
            q_loop   <= DEF_LOOP;
            q_speed  <= DEF_SPEED;
            q_an_en  <= DEF_AN_EN;
            q_pdown  <= DEF_PDOWN;
            q_duplex <= DEF_DUPLEX;
        end else if (load_new) begin
            q_loop   <= d_loop;
            q_pdown  <= d_pdown;
            q_duplex <= d_duplex;
            if (!fiber_mode) begin
                q_speed <= d_speed;
                q_an_en <= d_an_en;
            end
        end
    end

    assert_fiber_locks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fiber_mode && !load_def) |=> ($stable(q_speed) && $stable(q_an_en)));
    assert_write_in_pdown_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q_pdown && load_new) |=> (q_loop == $past(d_loop)));
endmodule

// File: rtl/bmcr_view.sv
module bmcr_view
    import bmcr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fiber_mode,
    input  logic             an_done,
    input  logic             an_speed_100,
    input  logic             an_full_duplex,
    input  logic             q_loop,
    input  logic             q_speed,
    input  logic             q_an_en,
    input  logic             q_pdown,
    input  logic             q_duplex,
    output logic             an_enable,
    output logic             speed_100,
    output logic             full_duplex,
    output logic [REG_W-1:0] rd_data
);
    logic use_neg;

    always_comb begin
        an_enable   = q_an_en && !fiber_mode;
        use_neg     = an_enable && an_done;
        if (fiber_mode)   speed_100 = 1'b1;
        else if (use_neg) speed_100 = an_speed_100;
        else              speed_100 = q_speed;
        full_duplex = use_neg ? an_full_duplex : q_duplex;

        rd_data            = '0;
        rd_data[B_LOOP]    = q_loop;
        rd_data[B_SPEED]   = speed_100;
        rd_data[B_AN_EN]   = an_enable;
        rd_data[B_PDOWN]   = q_pdown;
        rd_data[B_DUPLEX]  = full_duplex;
    end

    assert_fiber_forced_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fiber_mode |-> (rd_data[B_SPEED] && !rd_data[B_AN_EN]));
    assert_neg_speed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q_an_en && !fiber_mode && an_done) |-> (speed_100 == an_speed_100 && full_duplex == an_full_duplex));
    assert_forced_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!q_an_en && !fiber_mode) |-> (speed_100 == q_speed && full_duplex == q_duplex));
endmodule

// File: rtl/phy_bmcr.sv
module phy_bmcr
    import bmcr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    output logic [15:0] rd_data,
    input  logic        fiber_mode,
    input  logic        an_done,
    input  logic        an_speed_100,
    input  logic        an_full_duplex,
    output logic        soft_reset_pulse,
    output logic        an_restart_pulse,
    output logic        loopback_en,
    output logic        power_down,
    output logic        an_enable,
    output logic        speed_100,
    output logic        full_duplex
);
    logic wr_accept;
    logic q_loop, q_speed, q_an_en, q_pdown, q_duplex;
    logic unused_rsvd;

    assign unused_rsvd = ^{wr_data[10], wr_data[7:0]};

    bmcr_seq u_seq (
        .clk              (clk),
        .rst_n            (rst_n),
        .wr_en            (wr_en),
        .cmd_reset        (wr_data[B_SWRST]),
        .cmd_restart      (wr_data[B_RESTART]),
        .wr_accept        (wr_accept),
        .soft_reset_pulse (soft_reset_pulse),
        .an_restart_pulse (an_restart_pulse)
    );

    bmcr_fields u_fields (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_accept  (wr_accept),
        .cmd_reset  (wr_data[B_SWRST]),
        .fiber_mode (fiber_mode),
        .d_loop     (wr_data[B_LOOP]),
        .d_speed    (wr_data[B_SPEED]),
        .d_an_en    (wr_data[B_AN_EN]),
        .d_pdown    (wr_data[B_PDOWN]),
        .d_duplex   (wr_data[B_DUPLEX]),
        .q_loop     (q_loop),
        .q_speed    (q_speed),
        .q_an_en    (q_an_en),
        .q_pdown    (q_pdown),
        .q_duplex   (q_duplex)
    );

    bmcr_view u_view (
        .clk            (clk),
        .rst_n          (rst_n),
        .fiber_mode     (fiber_mode),
        .an_done        (an_done),
        .an_speed_100   (an_speed_100),
        .an_full_duplex (an_full_duplex),
        .q_loop         (q_loop),
        .q_speed        (q_speed),
        .q_an_en        (q_an_en),
        .q_pdown        (q_pdown),
        .q_duplex       (q_duplex),
        .an_enable      (an_enable),
        .speed_100      (speed_100),
        .full_duplex    (full_duplex),
        .rd_data        (rd_data)
    );

    assign loopback_en = q_loop;
    assign power_down  = q_pdown;

    assert_defaults_in_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_reset_pulse |-> (!loopback_en && !power_down && !rd_data[B_SWRST]));
    assert_self_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[B_RESTART] == 1'b0) && (rd_data[B_SWRST] == 1'b0));
endmodule

// File: tb/test_phy_bmcr.sv
module test_phy_bmcr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        fiber_mode = 1'b0, an_done = 1'b0, an_speed_100 = 1'b0, an_full_duplex = 1'b0;
    logic [15:0] rd_data;
    logic        soft_reset_pulse, an_restart_pulse, loopback_en, power_down;
    logic        an_enable, speed_100, full_duplex;
    int          n_checks = 0;
    int          n_fail = 0;

    always #5 clk = ~clk;

    phy_bmcr i_phy_bmcr (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .fiber_mode(fiber_mode), .an_done(an_done), .an_speed_100(an_speed_100),
        .an_full_duplex(an_full_duplex), .soft_reset_pulse(soft_reset_pulse),
        .an_restart_pulse(an_restart_pulse), .loopback_en(loopback_en),
        .power_down(power_down), .an_enable(an_enable), .speed_100(speed_100),
        .full_duplex(full_duplex)
    );

    task automatic check(input string what, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", what, got, exp);
        end
    endtask

    // Drive at a falling edge; return at the next falling edge, just after the write edge.
    task automatic reg_write(input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    task automatic t_reset_defaults();
        check("R1 rd_data", rd_data, 16'h1000);
        check("R1 outputs", {11'd0, loopback_en, power_down, speed_100, full_duplex, an_enable}, 16'h0001);
        check("R1 pulses", {14'd0, soft_reset_pulse, an_restart_pulse}, 16'h0000);
    endtask

    task automatic t_loopback();
        reg_write(16'h5000);
        check("R2 rd_data", rd_data, 16'h5000);
        check("R2 loopback_en", {15'd0, loopback_en}, 16'h0001);
    endtask

    task automatic t_forced();
        reg_write(16'h2100);
        an_done = 1'b1; an_speed_100 = 1'b0; an_full_duplex = 1'b0;
        #1;
        check("R3 rd_data", rd_data, 16'h2100);
        check("R3 speed/duplex/an", {13'd0, speed_100, full_duplex, an_enable}, 16'h0006);
        reg_write(16'h0000);
        check("R3 10M half", {14'd0, speed_100, full_duplex}, 16'h0000);
        an_done = 1'b0;
    endtask

    task automatic t_negotiated();
        reg_write(16'h1000);
        an_done = 1'b1; an_speed_100 = 1'b1; an_full_duplex = 1'b1;
        #1;
        check("R4 rd_data done", rd_data, 16'h3100);
        check("R4 outputs done", {14'd0, speed_100, full_duplex}, 16'h0003);
        an_done = 1'b0;
        #1;
        check("R4 rd_data not done", rd_data, 16'h1000);
        an_speed_100 = 1'b0; an_full_duplex = 1'b0;
    endtask

    task automatic t_fiber();
        fiber_mode = 1'b1;
        #1;
        check("R5 rd_data", rd_data, 16'h2000);
        check("R5 speed/an", {14'd0, speed_100, an_enable}, 16'h0002);
        reg_write(16'h0100);
        check("R5 write ignored", rd_data, 16'h2100);
        check("R5 duplex", {15'd0, full_duplex}, 16'h0001);
        fiber_mode = 1'b0;
        #1;
        check("R5 released", rd_data, 16'h1100);
    endtask

    task automatic t_power_down();
        reg_write(16'h1800);
        check("R6 power_down", {15'd0, power_down}, 16'h0001);
        reg_write(16'h5800);
        check("R6 write while down", rd_data, 16'h5800);
    endtask

    task automatic t_reserved();
        reg_write(16'h14FF);
        check("R9 reserved read 0", rd_data, 16'h1000);
    endtask

    task automatic t_restart();
        reg_write(16'h1200);
        check("R7 pulse high", {15'd0, an_restart_pulse}, 16'h0001);
        check("R7 bit9 reads 0", rd_data, 16'h1000);
        @(negedge clk);
        check("R7 pulse cleared", {15'd0, an_restart_pulse}, 16'h0000);
    endtask

    task automatic t_soft_reset();
        reg_write(16'h7900);
        reg_write(16'hC000);
        check("R8 pulse high", {15'd0, soft_reset_pulse}, 16'h0001);
        check("R8 defaults", rd_data, 16'h1000);
        wr_en = 1'b1; wr_data = 16'h4000;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
        check("R8 pulse one cycle", {15'd0, soft_reset_pulse}, 16'h0000);
        check("R8 write in pulse ignored", rd_data, 16'h1000);
    endtask

    task automatic t_reset_and_restart();
        reg_write(16'h8200);
        check("R10 reset pulse", {14'd0, soft_reset_pulse, an_restart_pulse}, 16'h0002);
        @(negedge clk);
        check("R10 no restart", {15'd0, an_restart_pulse}, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_defaults();
        t_loopback();
        t_forced();
        t_negotiated();
        t_fiber();
        t_power_down();
        t_reserved();
        t_restart();
        t_soft_reset();
        t_reset_and_restart();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule